// File: doc/BRIEF.md
# Digital Audio Interface Frame and Status Sequencer

This block sits between the stereo sample path and the biphase-mark line encoder of a consumer digital audio transmitter. Each incoming audio word is a subframe, tagged as the first (A) or second (B) half of a stereo frame. For each subframe the block registers the audio word and attaches four bits: validity, user, channel status and parity. It also attaches the preamble code for that subframe. A frame counter runs over a 192-frame block.

In automatic mode the block decides on its own where a block starts, and it supplies the validity and channel-status bits from its configuration inputs. In manual mode the block start, validity and channel-status bits come in with the stream. A stream block-start flag then realigns the counter. In either mode, an optional external sync can clear the frame counter. The sync counts only when the internal word clock rises first and the external sync pin rises after it.

User bits come from a host-loaded buffer for each side. A load is staged, and it reaches the working buffer only when the next block starts. A pending flag stays high until that transfer has taken place.

Top module: `spdif_frame_seq`

## Requirements
- R1: Frame indices run 0 to 191 and wrap back to 0. Both subframes of a frame carry the same index on `frame_o`. In automatic mode the index of each A subframe is one more than that of the previous A subframe, modulo 192.
- R2: In manual mode, an A subframe with `str_blk_i`=1 takes index 0, and the count continues from there. In manual mode `v_o` follows `str_valid_i` and `c_o` follows `str_cs_i`.
- R3: `pre_o` is 2'b00 for a block start, 2'b01 for an ordinary A subframe and 2'b10 for every B subframe. A block start is the A subframe of frame 0 in automatic mode, and an A subframe with `str_blk_i`=1 in manual mode.
- R4: In automatic mode, `v_o` equals `valid_a_i` on A subframes and `valid_b_i` on B subframes.
- R5: In automatic mode, `c_o` for frame n < 8 is bit n of `cs_byte0_a_i` on A subframes or bit n of `cs_byte0_b_i` on B subframes. For n >= 8, `c_o` is 0.
- R6: `blk_start_o` is 1 only on the A subframe of frame 0 in automatic mode. It is always 0 in manual mode.
- R7: A pulse on `user_load_i` stages `user_a_i` and `user_b_i` and sets `usr_pend_o`. At the next A subframe with index 0, the staged words move into the working buffers and `usr_pend_o` clears. `u_o` is bit (index mod 32) of the working buffer for the side. The frame-0 subframes already use the new contents.
- R8: `p_o` makes the total count of ones in `audio_o` (24 bits), `v_o`, `u_o`, `c_o` and `p_o` even.
- R9: When `ext_sync_en_i`=1, a rising edge on `ext_sync_i` that follows a rising edge on `word_clk_i` makes the next A subframe frame 0, in either mode. An external sync edge does nothing if no word-clock rise came before it, and it does nothing when `ext_sync_en_i`=0.
- R10: Outputs appear with `out_valid_o`=1 in the cycle after `sub_valid_i`, and `audio_o` equals the input word. `out_valid_o` is 0 in a cycle with no subframe.
- R11: After reset all outputs are 0. The first A subframe is frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_mode_i | input | 1 | 1 = automatic mode, 0 = manual mode |
| valid_a_i | input | 1 | Validity bit for A subframes (automatic mode) |
| valid_b_i | input | 1 | Validity bit for B subframes (automatic mode) |
| cs_byte0_a_i | input | 8 | Channel-status byte 0 for A subframes |
| cs_byte0_b_i | input | 8 | Channel-status byte 0 for B subframes |
| ext_sync_en_i | input | 1 | Enables frame counter alignment to external sync |
| word_clk_i | input | 1 | Internal word clock level |
| ext_sync_i | input | 1 | External sync input |
| user_load_i | input | 1 | Stages the user words |
| user_a_i | input | 32 | User bits for A subframes |
| user_b_i | input | 32 | User bits for B subframes |
| sub_valid_i | input | 1 | Subframe strobe |
| sub_b_i | input | 1 | 1 = B subframe, 0 = A subframe |
| audio_i | input | 24 | Audio word |
| str_blk_i | input | 1 | Stream block-start flag (manual mode) |
| str_valid_i | input | 1 | Stream validity bit (manual mode) |
| str_cs_i | input | 1 | Stream channel-status bit (manual mode) |
| out_valid_o | output | 1 | Subframe output strobe |
| pre_o | output | 2 | Preamble code |
| audio_o | output | 24 | Audio word |
| v_o | output | 1 | Validity bit |
| u_o | output | 1 | User bit |
| c_o | output | 1 | Channel-status bit |
| p_o | output | 1 | Parity bit |
| frame_o | output | 8 | Frame index of the subframe |
| blk_start_o | output | 1 | Current word is block start (automatic mode) |
| usr_pend_o | output | 1 | User buffer transfer pending |

## Verification
The bench runs through the 191-to-0 wrap several times. A counter that stopped at 191, or overran it, would put the block-start preamble on the wrong frame and misplace the channel-status bits. It loads user words in the middle of a block and checks that they take effect only at frame 0, with the pending flag clearing at that point. A buffer that updated at once, or one that missed frame 0 itself, would show up as wrong user bits.

External sync is tried three ways: armed by a word-clock rise, unarmed, and disabled. Only the first case may move the count. The bench also inserts stream block-start flags at arbitrary points in manual mode, so that a design still using internal timing or configured validity would disagree on the frame index and preamble.

// File: rtl/spdif_seq_pkg.sv
package spdif_seq_pkg;
  typedef enum logic [1:0] {
    PRE_BLK = 2'd0,
    PRE_A   = 2'd1,
    PRE_B   = 2'd2
  } pre_e;
endpackage

// File: rtl/spdif_frame_ctr.sv
module spdif_frame_ctr #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_a_i,
  input  logic          blk_force_i,
  input  logic          ext_sync_en_i,
  input  logic          word_clk_i,
  input  logic          ext_sync_i,
  output logic [FW-1:0] idx_a_o,
  output logic [FW-1:0] cur_o
);
  logic [FW-1:0] n_q, cur_q, idx;
  logic wc_q, es_q, armed_q;
  logic wc_rise, es_rise, sync_fire;

  assign wc_rise   = word_clk_i & ~wc_q;
  assign es_rise   = ext_sync_i & ~es_q;
  assign sync_fire = ext_sync_en_i & armed_q & es_rise;
  assign idx       = blk_force_i ? '0 : n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q    <= 1'b0;
      es_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      wc_q <= word_clk_i;
      es_q <= ext_sync_i;
      if (!ext_sync_en_i)  armed_q <= 1'b0;
      else if (wc_rise)    armed_q <= 1'b1;
      else if (sync_fire)  armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      cur_q <= '0;
    end else begin
      if (sync_fire)
        n_q <= '0;
      else if (strobe_a_i)
        n_q <= (idx == FW'(FRAMES - 1)) ? '0 : idx + 1'b1;
      if (strobe_a_i) cur_q <= idx;
    end
  end

  assign idx_a_o = idx;
  assign cur_o   = cur_q;

  AST_FRAME_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_q < FW'(FRAMES)); // R1
  AST_SYNC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_fire |=> (n_q == '0)); // R9
endmodule

// File: rtl/spdif_user_buf.sv
module spdif_user_buf #(
  parameter int USR_W = 32,
  parameter int FW    = 8,
  localparam int UIW  = $clog2(USR_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [USR_W-1:0] host_a_i,
  input  logic [USR_W-1:0] host_b_i,
  input  logic             xfer_req_i,
  input  logic             sel_b_i,
  input  logic [FW-1:0]    idx_i,
  output logic             user_bit_o,
  output logic             pend_o
);
  logic [USR_W-1:0] host_a_q, host_b_q, buf_a_q, buf_b_q, buf_a_nx;
  logic             pend_q, xfer;
  logic [UIW-1:0]   bsel;

  assign xfer     = xfer_req_i & pend_q;
  assign buf_a_nx = xfer ? host_a_q : buf_a_q;
  assign bsel     = UIW'(idx_i % FW'(USR_W));
  // B side is read after the A-edge transfer, so the register already holds new data
  assign user_bit_o = sel_b_i ? buf_b_q[bsel] : buf_a_nx[bsel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_a_q <= '0;
      host_b_q <= '0;
      buf_a_q  <= '0;
      buf_b_q  <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (xfer) begin
        buf_a_q <= host_a_q;
        buf_b_q <= host_b_q;
      end
      if (load_i) begin
        host_a_q <= host_a_i;
        host_b_q <= host_b_i;
        pend_q   <= 1'b1;
      end else if (xfer) begin
        pend_q   <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pend_q); // R7
  AST_PEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && !load_i) |=> !pend_q); // R7
endmodule

// File: rtl/spdif_subframe_fmt.sv
module spdif_subframe_fmt
  import spdif_seq_pkg::*;
#(
  parameter int AW   = 24,
  parameter int FW   = 8,
  parameter int CS_W = 8,
  localparam int CIW = $clog2(CS_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strobe_i,
  input  logic            sel_b_i,
  input  logic            auto_i,
  input  logic            blk_force_i,
  input  logic [FW-1:0]   idx_i,
  input  logic            valid_a_i,
  input  logic            valid_b_i,
  input  logic [CS_W-1:0] cs_a_i,
  input  logic [CS_W-1:0] cs_b_i,
  input  logic            str_valid_i,
  input  logic            str_cs_i,
  input  logic            user_bit_i,
  input  logic [AW-1:0]   audio_i,
  output logic            out_valid_o,
  output logic [1:0]      pre_o,
  output logic [AW-1:0]   audio_o,
  output logic            v_o,
  output logic            u_o,
  output logic            c_o,
  output logic            p_o,
  output logic [FW-1:0]   frame_o,
  output logic            blk_start_o
);
  logic v_d, c_d, p_d, blk_d, cs_bit;
  pre_e pre_d;

  assign cs_bit = (idx_i < FW'(CS_W)) &
                  (sel_b_i ? cs_b_i[idx_i[CIW-1:0]] : cs_a_i[idx_i[CIW-1:0]]);

  always_comb begin
    if (auto_i) begin
      v_d   = sel_b_i ? valid_b_i : valid_a_i;
      c_d   = cs_bit;
      blk_d = ~sel_b_i & (idx_i == '0);
    end else begin
      v_d   = str_valid_i;
      c_d   = str_cs_i;
      blk_d = ~sel_b_i & blk_force_i;
    end
    if (sel_b_i)    pre_d = PRE_B;
    else if (blk_d) pre_d = PRE_BLK;
    else            pre_d = PRE_A;
    p_d = ^{audio_i, v_d, user_bit_i, c_d};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      pre_o       <= '0;
      audio_o     <= '0;
      v_o         <= 1'b0;
      u_o         <= 1'b0;
      c_o         <= 1'b0;
      p_o         <= 1'b0;
      frame_o     <= '0;
      blk_start_o <= 1'b0;
    end else begin
      out_valid_o <= strobe_i;
      if (strobe_i) begin
        pre_o       <= pre_d;
        audio_o     <= audio_i;
        v_o         <= v_d;
        u_o         <= user_bit_i;
        c_o         <= c_d;
        p_o         <= p_d;
        frame_o     <= idx_i;
        blk_start_o <= blk_d & auto_i;
      end
    end
  end

  AST_PARITY_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(^{audio_o, v_o, u_o, c_o, p_o})); // R8
  AST_BLK_FRAME0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pre_o == PRE_BLK) |-> (frame_o == '0)); // R3
  AST_BLK_FLAG_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_o |-> (pre_o == PRE_BLK)); // R6
  AST_BLK_AUTO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !auto_i) |=> !blk_start_o); // R6
  AST_OUT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(strobe_i)); // R10
endmodule

// File: rtl/spdif_frame_seq.sv
module spdif_frame_seq #(
  parameter int AW     = 24,
  parameter int FRAMES = 192,
  parameter int USR_W  = 32,
  parameter int CS_W   = 8,
  localparam int FW    = $clog2(FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_mode_i,
  input  logic             valid_a_i,
  input  logic             valid_b_i,
  input  logic [CS_W-1:0]  cs_byte0_a_i,
  input  logic [CS_W-1:0]  cs_byte0_b_i,
  input  logic             ext_sync_en_i,
  input  logic             word_clk_i,
  input  logic             ext_sync_i,
  input  logic             user_load_i,
  input  logic [USR_W-1:0] user_a_i,
  input  logic [USR_W-1:0] user_b_i,
  input  logic             sub_valid_i,
  input  logic             sub_b_i,
  input  logic [AW-1:0]    audio_i,
  input  logic             str_blk_i,
  input  logic             str_valid_i,
  input  logic             str_cs_i,
  output logic             out_valid_o,
  output logic [1:0]       pre_o,
  output logic [AW-1:0]    audio_o,
  output logic             v_o,
  output logic             u_o,
  output logic             c_o,
  output logic             p_o,
  output logic [FW-1:0]    frame_o,
  output logic             blk_start_o,
  output logic             usr_pend_o
);
  logic          strobe_a, blk_force, user_bit;
  logic [FW-1:0] idx_a, cur, idx;

  assign strobe_a  = sub_valid_i & ~sub_b_i;
  assign blk_force = ~auto_mode_i & str_blk_i & ~sub_b_i;
  assign idx       = sub_b_i ? cur : idx_a;

  spdif_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
    .clk_i, .rst_ni,
    .strobe_a_i    (strobe_a),
    .blk_force_i   (blk_force),
    .ext_sync_en_i,
    .word_clk_i,
    .ext_sync_i,
    .idx_a_o       (idx_a),
    .cur_o         (cur)
  );

  spdif_user_buf #(.USR_W(USR_W), .FW(FW)) u_ubuf (
    .clk_i, .rst_ni,
    .load_i     (user_load_i),
    .host_a_i   (user_a_i),
    .host_b_i   (user_b_i),
    .xfer_req_i (strobe_a && idx_a == '0),
    .sel_b_i    (sub_b_i),
    .idx_i      (idx),
    .user_bit_o (user_bit),
    .pend_o     (usr_pend_o)
  );

  spdif_subframe_fmt #(.AW(AW), .FW(FW), .CS_W(CS_W)) u_fmt (
    .clk_i, .rst_ni,
    .strobe_i    (sub_valid_i),
    .sel_b_i     (sub_b_i),
    .auto_i      (auto_mode_i),
    .blk_force_i (blk_force),
    .idx_i       (idx),
    .valid_a_i, .valid_b_i,
    .cs_a_i      (cs_byte0_a_i),
    .cs_b_i      (cs_byte0_b_i),
    .str_valid_i, .str_cs_i,
    .user_bit_i  (user_bit),
    .audio_i,
    .out_valid_o, .pre_o, .audio_o, .v_o, .u_o, .c_o, .p_o, .frame_o, .blk_start_o
  );
endmodule

// File: tb/spdif_frame_seq_tb.sv
module spdif_frame_seq_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        auto_mode_i = 1'b1, valid_a_i = 1'b0, valid_b_i = 1'b0;
  logic [7:0]  cs_byte0_a_i = '0, cs_byte0_b_i = '0;
  logic        ext_sync_en_i = 1'b0, word_clk_i = 1'b0, ext_sync_i = 1'b0;
  logic        user_load_i = 1'b0;
  logic [31:0] user_a_i = '0, user_b_i = '0;
  logic        sub_valid_i = 1'b0, sub_b_i = 1'b0;
  logic [23:0] audio_i = '0;
  logic        str_blk_i = 1'b0, str_valid_i = 1'b0, str_cs_i = 1'b0;
  logic        out_valid_o, v_o, u_o, c_o, p_o, blk_start_o, usr_pend_o;
  logic [1:0]  pre_o;
  logic [23:0] audio_o;
  logic [7:0]  frame_o;

  spdif_frame_seq u_dut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  int m_n = 0, m_cur = 0;
  logic [31:0] m_buf_a = '0, m_buf_b = '0, m_host_a = '0, m_host_b = '0;
  bit m_pend = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_cs(input bit b, input int n);
    if (n >= 8) return 1'b0;
    return b ? cs_byte0_b_i[n] : cs_byte0_a_i[n];
  endfunction

  task automatic do_sub(input bit b, input bit sblk, input bit sv, input bit sc);
    logic [23:0] aud;
    int idx;
    bit ev, eu, ec, ep, eblk;
    logic [1:0] epre;
    aud = 24'($urandom);
    if (!b) begin
      idx = (!auto_mode_i && sblk) ? 0 : m_n;
      m_cur = idx;
      m_n = (idx == 191) ? 0 : idx + 1;
      if (idx == 0 && m_pend) begin
        m_buf_a = m_host_a; m_buf_b = m_host_b; m_pend = 0;
      end
    end else idx = m_cur;
    eu = b ? m_buf_b[idx % 32] : m_buf_a[idx % 32];
    if (auto_mode_i) begin
      ev = b ? valid_b_i : valid_a_i;
      ec = exp_cs(b, idx);
      eblk = !b && idx == 0;
    end else begin
      ev = sv; ec = sc;
      eblk = !b && sblk;
    end
    epre = b ? 2'b10 : (eblk ? 2'b00 : 2'b01);
    ep = ^{aud, ev, eu, ec};
    sub_valid_i = 1'b1; sub_b_i = b; audio_i = aud;
    str_blk_i = sblk; str_valid_i = sv; str_cs_i = sc;
    @(negedge clk_i);
    sub_valid_i = 1'b0; str_blk_i = 1'b0;
    chk(out_valid_o == 1'b1 && audio_o == aud, "R10 strobe/audio", {out_valid_o, audio_o}, {1'b1, aud});
    chk(frame_o == 8'(idx), "R1 frame index", frame_o, idx);
    chk(pre_o == epre, "R3 preamble", pre_o, epre);
    chk(v_o == ev, auto_mode_i ? "R4 validity" : "R2 stream validity", v_o, ev);
    chk(c_o == ec, auto_mode_i ? "R5 channel status" : "R2 stream cs", c_o, ec);
    chk(u_o == eu, "R7 user bit", u_o, eu);
    chk(p_o == ep, "R8 parity", p_o, ep);
    chk(blk_start_o == (eblk && auto_mode_i), "R6 block start flag", blk_start_o, eblk && auto_mode_i);
    chk(usr_pend_o == m_pend, "R7 pending", usr_pend_o, m_pend);
    if ($urandom % 4 == 0) begin
      @(negedge clk_i);
      chk(out_valid_o == 1'b0, "R10 idle", out_valid_o, 0);
    end
  endtask

  task automatic do_frame(input bit sblk);
    do_sub(0, sblk, 1'($urandom), 1'($urandom));
    do_sub(1, 0, 1'($urandom), 1'($urandom));
  endtask

  task automatic load_user();
    m_host_a = $urandom; m_host_b = $urandom;
    user_a_i = m_host_a; user_b_i = m_host_b; user_load_i = 1'b1;
    @(negedge clk_i);
    user_load_i = 1'b0; m_pend = 1;
    chk(usr_pend_o == 1'b1, "R7 pending after load", usr_pend_o, 1);
  endtask

  task automatic sync_seq(input bit arm);
    if (arm) begin
      word_clk_i = 1'b1; @(negedge clk_i);
    end
    ext_sync_i = 1'b1; @(negedge clk_i);
    word_clk_i = 1'b0; ext_sync_i = 1'b0; @(negedge clk_i);
    if (arm && ext_sync_en_i) m_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk_i);
    chk({out_valid_o, pre_o, audio_o, v_o, u_o, c_o, p_o, frame_o, blk_start_o, usr_pend_o} == '0,
        "R11 reset outputs", {out_valid_o, pre_o, frame_o, usr_pend_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    valid_a_i = 1'b1; valid_b_i = 1'b0;
    cs_byte0_a_i = 8'hA5; cs_byte0_b_i = 8'h3C;
    load_user();
    // R11 / R1: first frames from reset start at 0, run through two wraps
    for (int i = 0; i < 400; i++) begin
      if (i == 100) load_user();
      if (i == 150) begin valid_a_i = 1'($urandom); valid_b_i = 1'($urandom); end
      if (i == 250) begin cs_byte0_a_i = 8'($urandom); cs_byte0_b_i = 8'($urandom); end
      do_frame(0);
    end
    // R9: disabled sync, unarmed sync, then armed sync in automatic mode
    for (int i = 0; i < 20; i++) do_frame(0);
    sync_seq(1);
    do_frame(0);
    ext_sync_en_i = 1'b1; @(negedge clk_i);
    sync_seq(0);
    do_frame(0);
    for (int i = 0; i < 30; i++) do_frame(0);
    load_user();
    sync_seq(1);
    for (int i = 0; i < 5; i++) do_frame(0);
    // R2: manual mode, stream block flags at arbitrary points
    auto_mode_i = 1'b0;
    for (int i = 0; i < 300; i++) do_frame(($urandom % 16) == 0);
    do_frame(1);
    for (int i = 0; i < 10; i++) do_frame(0);
    // R9 in manual mode
    sync_seq(1);
    for (int i = 0; i < 5; i++) do_frame(0);
    ext_sync_en_i = 1'b0; @(negedge clk_i);
    sync_seq(1);
    for (int i = 0; i < 5; i++) do_frame(0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule